// File: doc/BRIEF.md
# Selectable CRC Attachment Unit

This unit takes a message block of K bits, presented as a serial bit stream, and produces K+L bits. The first K output bits are the message bits themselves. The last L bits are a CRC computed over the message. Both streams move one bit per accepted beat under a valid/ready handshake. A last marker closes each block.

Each block chooses its own CRC. The choices are a 6-bit code, an 11-bit code and a 24-bit code. Each block also chooses whether the CRC register starts cleared or preset to all ones. A typical pairing:

- Short uplink control payloads use the 6- or 11-bit code with a cleared register.
- Broadcast payloads use the 24-bit code with a cleared register.
- Downlink control payloads use the 24-bit code with the preset register.

The unit sits in front of a channel coder. It stalls cleanly when the downstream stage holds off.

Top module: `crc_attach`

## Requirements
- R1: While a block's message is passing, each accepted input bit appears unchanged on `out_bit` in the same beat, in order, with `out_last` low.
- R2: After the beat carrying `in_last`, exactly L CRC bits follow, most significant first, so the output block holds K+L bits.
- R3: `in_sel` is sampled on the first beat of a block and holds for the whole block. The codes are:
  - 0 selects L=6 with x^6+x^5+1.
  - 1 selects L=11 with x^11+x^10+x^9+x^5+1.
  - 2 and 3 both select L=24 with x^24+x^23+x^21+x^20+x^17+x^15+x^13+x^12+x^8+x^4+x^2+x+1.
- R4: `in_init` is sampled on the first beat of a block. A value of 1 starts the CRC register at all ones, and 0 starts it at zero. No final XOR is applied.
- R5: `out_last` is high only on the final CRC bit of a block.
- R6: While CRC bits are being sent, `in_ready` is low, and any input beat offered then is not taken.
- R7: During the message phase, `in_ready` equals `out_ready`. When `out_ready` is low, no bit moves and the CRC state holds.
- R8: After reset, `out_valid` is low with no input, the unit is in the message phase, and the next beat starts a new block.
- R9: A block with K=1 (`in_last` on its first beat) is handled and yields 1+L bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat taken when high with `in_valid` |
| in_bit | input | 1 | Message bit |
| in_last | input | 1 | Marks the final message bit of a block |
| in_sel | input | 2 | CRC choice, sampled on the block's first beat |
| in_init | input | 1 | Register preset choice, sampled on the block's first beat |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_bit | output | 1 | Message bit or CRC bit |
| out_last | output | 1 | Marks the final CRC bit of a block |

## Verification
The bench targets the following corner cases:

- **Single-bit blocks.** In these, the first beat is also the last. A design that latched the CRC length one beat late would send a tail of the wrong length.
- **The preset option.** The bench uses all-zero messages with the preset on. A design that ignored the flag, or applied a final XOR, would then send an all-zero tail or an inverted one.
- **Select code 3, and changes of `in_sel` between blocks.** These expose a design that decodes only the defined codes, or that reads the code live rather than once per block.
- **Random backpressure on both sides, with input offered during the tail.** This catches a CRC register that advances on a stalled beat, and input that leaks into the tail phase.

// File: rtl/crc_attach_pkg.sv
package crc_attach_pkg;
  localparam int unsigned CRC_MAX_W = 24;
  localparam int unsigned CNT_W     = $clog2(CRC_MAX_W + 1);
  localparam int unsigned SEL_W     = 2;

  typedef logic [CRC_MAX_W-1:0] crc_t;
  typedef logic [CNT_W-1:0]     cnt_t;
  typedef logic [SEL_W-1:0]     sel_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_C6  = 2'd0,
    SEL_C11 = 2'd1,
    SEL_C24 = 2'd2,
    SEL_C24B = 2'd3
  } crc_sel_e;

  function automatic cnt_t sel_len(input sel_t s);
    case (crc_sel_e'(s))
      SEL_C6:  sel_len = cnt_t'(6);
      SEL_C11: sel_len = cnt_t'(11);
      default: sel_len = cnt_t'(24);
    endcase
  endfunction

  // Generator terms below the top power
  function automatic crc_t sel_poly(input sel_t s);
    case (crc_sel_e'(s))
      SEL_C6:  sel_poly = crc_t'(24'h000021);
      SEL_C11: sel_poly = crc_t'(24'h000621);
      default: sel_poly = crc_t'(24'hB2B117);
    endcase
  endfunction

  function automatic crc_t len_mask(input cnt_t len);
    len_mask = (crc_t'(1) << len) - crc_t'(1);
  endfunction
endpackage

// File: rtl/crc_attach_rst_sync.sv
module crc_attach_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/crc_attach_cfg.sv
module crc_attach_cfg
  import crc_attach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic take_i,
  input  sel_t sel_i,
  output cnt_t len_o,
  output crc_t poly_o
);
  sel_t sel_q, sel_d, sel_eff;

  always_comb begin
    sel_d   = take_i ? sel_i : sel_q;
    sel_eff = first_i ? sel_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (take_i) sel_q <= sel_d;
  end

  assign len_o  = sel_len(sel_eff);
  assign poly_o = sel_poly(sel_eff);

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_i |=> $stable(sel_q));
endmodule

// File: rtl/crc_attach_lfsr.sv
module crc_attach_lfsr
  import crc_attach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic init_i,
  input  logic msg_adv_i,
  input  logic shift_i,
  input  logic bit_i,
  input  cnt_t len_i,
  input  crc_t poly_i,
  output logic msb_o
);
  crc_t crc_q, crc_d, base, mask;
  logic fb, en;

  always_comb begin
    mask  = len_mask(len_i);
    base  = first_i ? (init_i ? mask : '0) : crc_q;
    fb    = base[len_i - cnt_t'(1)] ^ bit_i;
    en    = msg_adv_i | shift_i;
    crc_d = crc_q;
    if (msg_adv_i)    crc_d = ((base << 1) & mask) ^ (fb ? poly_i : '0);
    else if (shift_i) crc_d = (crc_q << 1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= '0;
    else if (en) crc_q <= crc_d;
  end

  assign msb_o = crc_q[len_i - cnt_t'(1)];

  // R7
  crc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_adv_i || shift_i) |=> $stable(crc_q));
  // R3
  crc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_i |-> ((crc_q & ~len_mask(len_i)) == '0));
endmodule

// File: rtl/crc_attach_ctrl.sv
module crc_attach_ctrl
  import crc_attach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  input  cnt_t len_i,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic tail_o,
  output logic first_o,
  output logic msg_adv_o,
  output logic shift_o
);
  logic tail_q, tail_d, first_q, first_d;
  cnt_t cnt_q, cnt_d;

  always_comb begin
    in_ready  = !tail_q && out_ready;
    msg_adv_o = in_ready && in_valid;
    shift_o   = tail_q && out_ready;
    out_valid = tail_q || in_valid;
    out_last  = tail_q && (cnt_q == '0);
    tail_d    = tail_q;
    first_d   = first_q;
    cnt_d     = cnt_q;
    if (msg_adv_o) begin
      first_d = 1'b0;
      if (in_last) begin
        tail_d = 1'b1;
        cnt_d  = len_i - cnt_t'(1);
      end
    end else if (shift_o) begin
      cnt_d = cnt_q - cnt_t'(1);
      if (cnt_q == '0) begin
        tail_d  = 1'b0;
        first_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q  <= 1'b0;
      first_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      tail_q  <= tail_d;
      first_q <= first_d;
      cnt_q   <= cnt_d;
    end
  end

  assign tail_o  = tail_q;
  assign first_o = first_q;

  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (!tail_q && first_q));
  // R7
  tail_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q && !out_ready) |=> (tail_q && $stable(cnt_q)));
  // R2
  tail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q |-> (cnt_q < len_i));
  // R5
  tail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tail_q) |-> $past(out_last && out_ready));
endmodule

// File: rtl/crc_attach.sv
module crc_attach
  import crc_attach_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  input  logic       in_last,
  input  logic [1:0] in_sel,
  input  logic       in_init,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_bit,
  output logic       out_last
);
  logic rst_n, tail, first, msg_adv, shift, crc_msb;
  cnt_t len;
  crc_t poly;

  crc_attach_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  crc_attach_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .out_ready(out_ready), .len_i(len), .in_ready(in_ready),
    .out_valid(out_valid), .out_last(out_last), .tail_o(tail),
    .first_o(first), .msg_adv_o(msg_adv), .shift_o(shift)
  );

  crc_attach_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .first_i(first), .take_i(first && msg_adv),
    .sel_i(in_sel), .len_o(len), .poly_o(poly)
  );

  crc_attach_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .first_i(first), .init_i(in_init),
    .msg_adv_i(msg_adv), .shift_i(shift), .bit_i(in_bit), .len_i(len),
    .poly_i(poly), .msb_o(crc_msb)
  );

  assign out_bit = tail ? crc_msb : in_bit;

  // R6
  tail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !in_ready);
endmodule

// File: tb/crc_attach_bench.sv
`timescale 1ns/1ps
module crc_attach_bench;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, in_init = 1'b0;
  logic [1:0] in_sel = 2'd0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  crc_attach u_crc_attach (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .in_sel(in_sel), .in_init(in_init),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_last(out_last)
  );

  function automatic int ref_len(input logic [1:0] s);
    return (s == 2'd0) ? 6 : (s == 2'd1) ? 11 : 24;
  endfunction

  function automatic bit [23:0] ref_poly(input logic [1:0] s);
    return (s == 2'd0) ? 24'h000021 : (s == 2'd1) ? 24'h000621 : 24'hB2B117;
  endfunction

  function automatic bit [23:0] ref_crc(input logic [1:0] s, input bit init,
                                        input bit [63:0] msg, input int k);
    int len = ref_len(s);
    bit [23:0] mask = (len == 24) ? 24'hFFFFFF : ((24'd1 << len) - 24'd1);
    bit [23:0] r = init ? mask : 24'd0;
    bit fb;
    for (int i = 0; i < k; i++) begin
      fb = r[len-1] ^ msg[i];
      r  = (r << 1) & mask;
      if (fb) r = r ^ ref_poly(s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_block(input int k, input bit [63:0] msg, input logic [1:0] sel,
                           input bit init, input int vpct, input int rpct);
    int len = ref_len(sel);
    int total = k + len;
    bit [23:0] crc = ref_crc(sel, init, msg, k);
    int ii = 0;
    int oi = 0;
    bit eb;
    while (oi < total) begin
      @(posedge clk); #1;
      if (ii < k) begin
        in_valid = (int'($urandom % 100) < vpct);
        in_bit   = msg[ii];
        in_last  = (ii == k - 1);
        in_sel   = sel;
        in_init  = init;
      end else begin
        in_valid = ($urandom % 3 == 0);
        in_bit   = 1'($urandom);
        in_last  = 1'($urandom);
        in_sel   = 2'($urandom);
        in_init  = 1'($urandom);
      end
      out_ready = (int'($urandom % 100) < rpct);
      @(negedge clk);
      if (ii >= k && in_valid) check(in_ready == 1'b0, "R6 in_ready in tail", int'(in_ready), 0);
      if (oi < k) check(in_ready == out_ready, "R7 in_ready follows out_ready", int'(in_ready), int'(out_ready));
      if (out_valid && out_ready) begin
        if (oi < k) begin
          eb = msg[oi];
          check(out_bit == eb, "R1 message bit", int'(out_bit), int'(eb));
        end else begin
          eb = crc[len - 1 - (oi - k)];
          check(out_bit == eb, "R2 R3 R4 crc bit", int'(out_bit), int'(eb));
        end
        check(out_last == (oi == total - 1), "R5 out_last", int'(out_last), int'(oi == total - 1));
        oi++;
      end
      if (in_valid && in_ready && ii < k) ii++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: idle after reset
    check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8 message phase after reset", int'(in_ready), 1);
    // R9: single-bit blocks, each length
    run_block(1, 64'd0, 2'd0, 1'b0, 100, 100);
    run_block(1, 64'd1, 2'd0, 1'b0, 100, 100);
    run_block(1, 64'd1, 2'd1, 1'b0, 100, 100);
    run_block(1, 64'd1, 2'd2, 1'b1, 100, 100);
    // R4: preset register on zero message
    run_block(8, 64'd0, 2'd2, 1'b1, 100, 100);
    run_block(8, 64'd0, 2'd0, 1'b1, 100, 100);
    // R3: code 3 aliases the 24-bit choice
    run_block(40, {$urandom, $urandom}, 2'd3, 1'b0, 100, 100);
    run_block(64, {64{1'b1}}, 2'd1, 1'b1, 70, 60);
    for (int b = 0; b < 60; b++) begin
      run_block(1 + int'($urandom % 64), {$urandom, $urandom}, 2'($urandom),
                1'($urandom), 40 + int'($urandom % 61), 30 + int'($urandom % 71));
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle after last block", int'(out_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule